// File: doc/BRIEF.md
# Skewed Voxel Address Mapper

The mapper turns an unskewed voxel coordinate (x, y, z) inside an N×N×N volume into a pair: the memory module that holds the voxel and the word address inside that module. It spreads voxels over C parallel modules with a diagonal skew. The module is picked from the sum x+y+z, not from the low bits of one coordinate. Because of this, any C neighbouring voxels along a beam lie in C different modules. This holds whether the beam runs along x, y or z, so a whole partial beam can be fetched in one cycle for any viewing axis.

A mode input selects block granularity. In that mode the same skew is applied to block coordinates (x/b, y/b, z/b) of b×b×b blocks. All voxels of one block then share a module, and each block takes a contiguous run of b³ addresses, ordered x fastest and then y and z. N, C and b are powers of two, with N a multiple of C and b ≤ N/C. Coordinates enter through a valid/ready handshake. The result leaves through a registered valid/ready stage one cycle later.

Top module: `skew_addr_mapper`

## Requirements
- R1: While reset is asserted and after it is released with no input, out_valid is 0 and in_ready is 1.
- R2: In voxel mode (blk_mode=0), out_mod equals (x+y+z) mod C.
- R3: In voxel mode, out_addr equals floor(i/C) + y·(N/C) + z·(N²/C), where i = (x+y+z) mod N.
- R4: In voxel mode, the N³ coordinates map one-to-one onto the C·(N³/C) pairs (out_mod, out_addr).
- R5: In voxel mode, for each axis, every aligned group of C consecutive voxels along that axis (positions g·C to g·C+C−1, other coordinates fixed) maps to C distinct modules.
- R6: In block mode (blk_mode=1), out_mod equals ((x/b)+(y/b)+(z/b)) mod C. Every voxel of a block therefore has the same module.
- R7: In block mode, out_addr equals A·b³ + (x mod b) + (y mod b)·b + (z mod b)·b². Here A = floor(j/C) + (y/b)·(M/C) + (z/b)·(M²/C), with M = N/b and j = ((x/b)+(y/b)+(z/b)) mod M.
- R8: In block mode, the mapping is also one-to-one over the full volume, and the origin voxel of each block has an address that is a multiple of b³.
- R9: In block mode, for each axis, every aligned group of C consecutive blocks along that axis maps to C distinct modules.
- R10: A coordinate accepted on a clock edge (in_valid and in_ready both 1) shows up on out_mod/out_addr with out_valid=1 after exactly that one edge.
- R11: While out_valid=1 and out_ready=0, in_ready is 0, the outputs hold steady, and any coordinate offered on the input is not taken.
- R12: When a result is consumed and a new coordinate is accepted on the same edge, out_valid stays 1 and the new result replaces the old one with no empty cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Coordinate offered |
| in_ready | output | 1 | Mapper can take a coordinate this cycle |
| blk_mode | input | 1 | 0 = voxel skew, 1 = block skew |
| coord_x | input | LOG_N | Voxel x coordinate |
| coord_y | input | LOG_N | Voxel y coordinate |
| coord_z | input | LOG_N | Voxel z coordinate |
| out_valid | output | 1 | Result held on outputs |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_mod | output | LOG_C | Memory module index |
| out_addr | output | 3·LOG_N−LOG_C | Word address inside the module |

## Verification
Two things can fall on the same clock edge: the consumer draining the held result, and a new coordinate being captured. The bench provokes this in two ways. In the full-volume sweeps it streams one coordinate per cycle with out_ready high, so every cycle both drains and captures. It also builds a stall and then releases out_ready while a fresh coordinate waits. In both cases a pass means out_valid never drops, each output matches the arithmetic value for the coordinate taken one edge earlier, and nothing is lost or duplicated. The duplicate check comes from the one-to-one tally. Stalled cycles are judged by requiring the held pair to stay unchanged while the waiting coordinate is refused.

// File: rtl/skew_pkg.sv
package skew_pkg;
  typedef enum logic {
    MAP_VOXEL = 1'b0,
    MAP_BLOCK = 1'b1
  } map_mode_e;
endpackage

// File: rtl/skew_voxel_map.sv
module skew_voxel_map #(
  parameter int LOG_N = 4,
  parameter int LOG_C = 2,
  localparam int AW   = 3 * LOG_N - LOG_C
) (
  input  logic [LOG_N-1:0] cx,
  input  logic [LOG_N-1:0] cy,
  input  logic [LOG_N-1:0] cz,
  output logic [LOG_C-1:0] mod_idx,
  output logic [AW-1:0]    word_addr
);
  logic [LOG_N-1:0] diag;

  // Sum wraps at N naturally in LOG_N bits.
  always_comb begin
    diag      = cx + cy + cz;
    mod_idx   = diag[LOG_C-1:0];
    word_addr = {cz, cy, diag[LOG_N-1:LOG_C]};
  end
endmodule

// File: rtl/skew_block_map.sv
module skew_block_map #(
  parameter int LOG_N = 4,
  parameter int LOG_C = 2,
  parameter int LOG_B = 1,
  localparam int LBN  = LOG_N - LOG_B,
  localparam int AW   = 3 * LOG_N - LOG_C
) (
  input  logic [LOG_N-1:0] cx,
  input  logic [LOG_N-1:0] cy,
  input  logic [LOG_N-1:0] cz,
  output logic [LOG_C-1:0] mod_idx,
  output logic [AW-1:0]    word_addr
);
  logic [LBN-1:0] bx, by, bz, bdiag;

  always_comb begin
    bx    = cx[LOG_N-1:LOG_B];
    by    = cy[LOG_N-1:LOG_B];
    bz    = cz[LOG_N-1:LOG_B];
    bdiag = bx + by + bz;
    mod_idx = bdiag[LOG_C-1:0];
  end

  generate
    if (LBN > LOG_C) begin : g_wide
      always_comb
        word_addr = {bz, by, bdiag[LBN-1:LOG_C],
                     cz[LOG_B-1:0], cy[LOG_B-1:0], cx[LOG_B-1:0]};
    end else begin : g_edge
      // b == N/C: each module holds one block per block-beam.
      always_comb
        word_addr = {bz, by, cz[LOG_B-1:0], cy[LOG_B-1:0], cx[LOG_B-1:0]};
    end
  endgenerate
endmodule

// File: rtl/skew_addr_mapper.sv
module skew_addr_mapper
  import skew_pkg::*;
#(
  parameter int LOG_N = 4,
  parameter int LOG_C = 2,
  parameter int LOG_B = 1,
  localparam int AW   = 3 * LOG_N - LOG_C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             blk_mode,
  input  logic [LOG_N-1:0] coord_x,
  input  logic [LOG_N-1:0] coord_y,
  input  logic [LOG_N-1:0] coord_z,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [LOG_C-1:0] out_mod,
  output logic [AW-1:0]    out_addr
);
  // reset: async assert, sync release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // mapping paths
  logic [LOG_C-1:0] vox_mod, blk_mod, sel_mod;
  logic [AW-1:0]    vox_addr, blk_addr, sel_addr;
  map_mode_e        mode;

  skew_voxel_map #(.LOG_N(LOG_N), .LOG_C(LOG_C)) u_vox (
    .cx(coord_x), .cy(coord_y), .cz(coord_z),
    .mod_idx(vox_mod), .word_addr(vox_addr)
  );

  generate
    if (LOG_B > 0) begin : g_blk
      skew_block_map #(.LOG_N(LOG_N), .LOG_C(LOG_C), .LOG_B(LOG_B)) u_blk (
        .cx(coord_x), .cy(coord_y), .cz(coord_z),
        .mod_idx(blk_mod), .word_addr(blk_addr)
      );
    end else begin : g_noblk
      always_comb begin
        blk_mod  = vox_mod;
        blk_addr = vox_addr;
      end
    end
  endgenerate

  always_comb begin
    mode     = map_mode_e'(blk_mode);
    sel_mod  = (mode == MAP_BLOCK) ? blk_mod  : vox_mod;
    sel_addr = (mode == MAP_BLOCK) ? blk_addr : vox_addr;
  end

  // output stage: next-state
  logic             vld_q, vld_d, take;
  logic [LOG_C-1:0] mod_q;
  logic [AW-1:0]    addr_q;

  always_comb begin
    in_ready = !vld_q || out_ready;
    take     = in_valid && in_ready;
    vld_d    = take || (vld_q && !out_ready);
  end

  // output stage: registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      vld_q  <= 1'b0;
      mod_q  <= '0;
      addr_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (take) begin
        mod_q  <= sel_mod;
        addr_q <= sel_addr;
      end
    end
  end

  assign out_valid = vld_q;
  assign out_mod   = mod_q;
  assign out_addr  = addr_q;

  // checks
  logic [LOG_N-1:0]       chk_sum;
  logic [LOG_N-LOG_B-1:0] chk_bsum;
  always_comb begin
    chk_sum  = coord_x + coord_y + coord_z;
    chk_bsum = coord_x[LOG_N-1:LOG_B] + coord_y[LOG_N-1:LOG_B]
             + coord_z[LOG_N-1:LOG_B];
  end

  assert_take_shows_R10: assert property (@(posedge clk) disable iff (!rst_q)
    take |=> out_valid);

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mod) && $stable(out_addr)));

  assert_no_bubble_R12: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_ready && in_valid) |=> out_valid);

  assert_voxel_module_R2: assert property (@(posedge clk) disable iff (!rst_q)
    (take && !blk_mode) |=> (out_mod == $past(chk_sum[LOG_C-1:0])));

  assert_block_module_R6: assert property (@(posedge clk) disable iff (!rst_q)
    (take && blk_mode) |=> (out_mod == $past(chk_bsum[LOG_C-1:0])));

  assert_drain_empty_R1: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: tb/skew_addr_mapper_test.sv
module skew_addr_mapper_test;
  localparam int LOG_N = 4, LOG_C = 2, LOG_B = 1;
  localparam int N = 16, C = 4, B = 2, M = N / B;
  localparam int AW = 3 * LOG_N - LOG_C;
  localparam int PERMOD = N * N * N / C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, blk_mode = 1'b0, out_ready = 1'b0;
  logic [LOG_N-1:0] cx = '0, cy = '0, cz = '0;
  logic in_ready, out_valid;
  logic [LOG_C-1:0] out_mod;
  logic [AW-1:0] out_addr;

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit seen [0:C*PERMOD-1];
  int modmap [0:N*N*N-1];

  always #4 clk = ~clk;

  skew_addr_mapper #(.LOG_N(LOG_N), .LOG_C(LOG_C), .LOG_B(LOG_B)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .blk_mode(blk_mode), .coord_x(cx), .coord_y(cy), .coord_z(cz),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_mod(out_mod), .out_addr(out_addr)
  );

  function automatic int exp_mod(int x, int y, int z, bit m);
    if (!m) return (x + y + z) % C;
    return ((x / B + y / B + z / B) % M) % C;
  endfunction

  function automatic int exp_addr(int x, int y, int z, bit m);
    int i, a;
    if (!m) begin
      i = (x + y + z) % N;
      return i / C + y * (N / C) + z * (N * N / C);
    end
    i = (x / B + y / B + z / B) % M;
    a = i / C + (y / B) * (M / C) + (z / B) * (M * M / C);
    return a * B * B * B + (x % B) + (y % B) * B + (z % B) * B * B;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_result(int x, int y, int z, bit m);
    int em, ea, key;
    em = exp_mod(x, y, z, m);
    ea = exp_addr(x, y, z, m);
    check(out_valid == 1'b1, "R10", out_valid, 1);
    check(int'(out_mod) == em, m ? "R6" : "R2", out_mod, em);
    check(int'(out_addr) == ea, m ? "R7" : "R3", out_addr, ea);
    key = int'(out_mod) * PERMOD + int'(out_addr);
    check(!seen[key], m ? "R8" : "R4", key, -1);
    seen[key] = 1'b1;
    modmap[x + y * N + z * N * N] = int'(out_mod);
    if (m && x % B == 0 && y % B == 0 && z % B == 0)
      check(int'(out_addr) % (B * B * B) == 0, "R8", out_addr % (B * B * B), 0);
  endtask

  // streams every voxel back to back: drain and capture share each edge (R12)
  task automatic sweep(bit m);
    int px, py, pz;
    for (int k = 0; k < C * PERMOD; k++) seen[k] = 1'b0;
    blk_mode = m;
    out_ready = 1'b1;
    for (int idx = 0; idx <= N * N * N; idx++) begin
      @(negedge clk);
      if (idx > 0) check_result(px, py, pz, m);
      if (idx < N * N * N) begin
        px = idx % N; py = (idx / N) % N; pz = idx / (N * N);
        cx = LOG_N'(px); cy = LOG_N'(py); cz = LOG_N'(pz);
        in_valid = 1'b1;
      end else in_valid = 1'b0;
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
  endtask

  task automatic conflict_voxel();
    for (int ax = 0; ax < 3; ax++)
      for (int u = 0; u < N; u++)
        for (int v = 0; v < N; v++)
          for (int g = 0; g < N / C; g++) begin
            int mask = 0;
            for (int k = 0; k < C; k++) begin
              int p = g * C + k, idx;
              if (ax == 0) idx = p + u * N + v * N * N;
              else if (ax == 1) idx = u + p * N + v * N * N;
              else idx = u + v * N + p * N * N;
              mask |= (1 << modmap[idx]);
            end
            check(mask == (1 << C) - 1, "R5", mask, (1 << C) - 1);
          end
  endtask

  task automatic conflict_block();
    for (int ax = 0; ax < 3; ax++)
      for (int u = 0; u < M; u++)
        for (int v = 0; v < M; v++)
          for (int g = 0; g < M / C; g++) begin
            int mask = 0;
            for (int k = 0; k < C; k++) begin
              int p = (g * C + k) * B, idx;
              if (ax == 0) idx = p + u * B * N + v * B * N * N;
              else if (ax == 1) idx = u * B + p * N + v * B * N * N;
              else idx = u * B + v * B * N + p * N * N;
              mask |= (1 << modmap[idx]);
            end
            check(mask == (1 << C) - 1, "R9", mask, (1 << C) - 1);
          end
  endtask

  task automatic stall_test();
    int ea, eb;
    blk_mode = 1'b0;
    out_ready = 1'b0;
    @(negedge clk);
    cx = 4'd3; cy = 4'd5; cz = 4'd7; in_valid = 1'b1;
    ea = exp_addr(3, 5, 7, 1'b0);
    @(negedge clk);
    check(out_valid == 1'b1 && int'(out_addr) == ea, "R10", out_addr, ea);
    cx = 4'd9; cy = 4'd1; cz = 4'd14;
    eb = exp_addr(9, 1, 14, 1'b0);
    check(in_ready == 1'b0, "R11", in_ready, 0);
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b1 && int'(out_addr) == ea, "R11", out_addr, ea);
      check(int'(out_mod) == exp_mod(3, 5, 7, 1'b0), "R11", out_mod, exp_mod(3, 5, 7, 1'b0));
    end
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R12", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1 && int'(out_addr) == eb, "R12", out_addr, eb);
    check(int'(out_mod) == exp_mod(9, 1, 14, 1'b0), "R12", out_mod, exp_mod(9, 1, 14, 1'b0));
    @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(in_ready == 1'b1, "R1", in_ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(in_ready == 1'b1, "R1", in_ready, 1);
    sweep(1'b0);
    conflict_voxel();
    sweep(1'b1);
    conflict_block();
    stall_test();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule